// File: doc/BRIEF.md
# Breakpoint and Program-Flow Trace Monitor

This block sits beside a processor core as a debug monitor. It watches the program fetch bus, the data address bus and a small status field from the core. When a trap condition occurs, it asks the core to stop by raising a trap request. There are three trap conditions: a fetch address equal to a programmed program comparator, a data access equal to a programmed data comparator, or any instruction fetch while single-step mode is on. Fetches marked as dummy are never treated as instructions. They take part neither in matching nor in flow tracking.

Alongside the breakpoint logic, a trace recorder keeps only the points where program flow jumps. Whenever a real fetch address is not one more than the previous real fetch address, the pair (previous address, new address) is stored as one entry of a 16-entry FIFO. Debug software reads the FIFO through a show-ahead read port and can rebuild the complete path from the pairs. When the FIFO is full, a new pair displaces the oldest one and a sticky overflow flag is set.

Trap sequencing is a three-state machine. In ST_WATCH the comparators are live. Transition T_HIT moves to ST_REQ, where the trap request is driven. Transition T_ACK moves to ST_HELD once the core reports trap-active. Transition T_RELEASE returns to ST_WATCH when trap-active drops. Software sets up the block through a small register port: CTRL at 0, program comparator at 1, data comparator at 2, STAT at 3.

Top module: `flowtrap_mon`

## Requirements
- R1: After reset, trap_req is 0, trc_empty is 1, trc_count is 0, trc_overflow is 0, and CTRL (address 0) reads 0.
- R2: With CTRL bit 0 set, a non-dummy fetch whose address equals the program comparator (address 1), seen in ST_WATCH while trap_active is low, drives trap_req high from the next cycle on.
- R3: With CTRL bit 1 set, a data access (data_valid high) whose address equals the data comparator (address 2) drives trap_req high from the next cycle. A different data address does not.
- R4: A comparator whose enable bit is clear never produces a trap. A fetch with fetch_dummy high never produces a program-match or single-step trap.
- R5: With CTRL bit 2 set (single step), every non-dummy fetch seen in ST_WATCH while trap_active is low raises trap_req in the next cycle.
- R6: trap_req stays high until trap_active is sampled high and is low in the following cycle. After that, no trap is raised until trap_active has been sampled low again.
- R7: On each trap, STAT (address 3) latches the cause flags and a snapshot of core_status. The cause flags are bit 2 for program match, bit 3 for data match and bit 4 for single step. The snapshot sits in bits 11:8. STAT bit 1 mirrors trap_req.
- R8: With CTRL bit 3 set, a non-dummy fetch whose address is not the previous non-dummy fetch address plus one pushes one entry: source = previous address, destination = new address. Sequential fetches push nothing.
- R9: Dummy fetches neither push an entry nor change the previous-address reference.
- R10: trc_src and trc_dst show the oldest entry while trc_empty is low. trc_rd_en pops it at the next clock edge.
- R11: A push into a full FIFO (16 entries) with no pop drops the oldest entry and sets trc_overflow (STAT bit 0). The flag stays set until STAT is written with bit 0 = 1.
- R12: CTRL, the program comparator and the data comparator read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| fetch_valid | input | 1 | Program fetch present this cycle |
| fetch_addr | input | AW | Program fetch address |
| fetch_dummy | input | 1 | Fetch is a dummy fetch |
| data_valid | input | 1 | Data access present this cycle |
| data_addr | input | AW | Data access address |
| core_status | input | 4 | Core status field, sampled at a trap |
| trap_active | input | 1 | Core is servicing a trap |
| trap_req | output | 1 | Trap request to the core |
| trc_rd_en | input | 1 | Pop the oldest trace entry |
| trc_src | output | AW | Source address of the oldest entry |
| trc_dst | output | AW | Destination address of the oldest entry |
| trc_empty | output | 1 | Trace FIFO empty |
| trc_count | output | $clog2(DEPTH+1) | Number of stored entries |
| trc_overflow | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that trap_active comes from the core only as a reply to trap_req. They also assume that trc_rd_en is raised only while entries are present. Without these assumptions, the hold and suppression properties would describe an unplanned handshake. The stimulus follows both rules. It raises trap_active only after a checked request. It pops only while trc_empty is low. It keeps fetch_valid low during reads and acknowledges, so every push comes from a fetch the scoreboard has already predicted.

// File: rtl/flowtrap_pkg.sv
package flowtrap_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_REQ   = 2'd1,
        ST_HELD  = 2'd2
    } trap_state_e;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_PCMP  = 3'd1;
    localparam logic [2:0] REG_DCMP  = 3'd2;
    localparam logic [2:0] REG_STAT  = 3'd3;

    localparam int CTRL_W     = 4;
    localparam int CB_PROG    = 0;
    localparam int CB_DATA    = 1;
    localparam int CB_STEP    = 2;
    localparam int CB_TRACE   = 3;

    localparam int SB_OVF     = 0;
    localparam int SB_REQ     = 1;
    localparam int SB_CAUSE   = 2;
    localparam int SB_SNAP    = 8;

    localparam int NCAUSE     = 3;
    localparam int STATUS_W   = 4;

endpackage

// File: rtl/flowtrap_cmp.sv
module flowtrap_cmp #(
    parameter int AW = 16
) (
    input  logic          enable,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] match_val,
    output logic          hit
);

    always_comb begin
        hit = enable && valid && (addr == match_val);
    end

endmodule

// File: rtl/flowtrap_disc.sv
module flowtrap_disc #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic          fetch_dummy,
    input  logic [AW-1:0] fetch_addr,
    input  logic          trace_en,
    output logic          push,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr
);

    logic [AW-1:0] prev_addr;
    logic          prev_ok;
    logic          real_fetch;
    logic [AW-1:0] succ_addr;

    always_comb begin
        real_fetch = fetch_valid && !fetch_dummy;
        succ_addr  = prev_addr + AW'(1);
        push       = trace_en && real_fetch && prev_ok && (fetch_addr != succ_addr);
        src_addr   = prev_addr;
        dst_addr   = fetch_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr <= '0;
            prev_ok   <= 1'b0;
        end else if (real_fetch) begin
            prev_addr <= fetch_addr;
            prev_ok   <= 1'b1;
        end
    end

endmodule

// File: rtl/flowtrap_fifo.sv
module flowtrap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    input  logic                       clr_ovf,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       overflow
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          full;
    logic          pop_ok;
    logic          drop;
    logic          adv_rd;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) begin
            return '0;
        end
        return p + PW'(1);
    endfunction

    always_comb begin
        full   = (cnt == CW'(DEPTH));
        pop_ok = pop && (cnt != '0);
        drop   = push && full && !pop_ok;
        adv_rd = pop_ok || drop;
        rdata  = mem[rd_ptr];
        empty  = (cnt == '0);
        count  = cnt;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (adv_rd) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !adv_rd) begin
                cnt <= cnt + CW'(1);
            end else if (!push && adv_rd) begin
                cnt <= cnt - CW'(1);
            end
            if (drop) begin
                overflow <= 1'b1;
            end else if (clr_ovf) begin
                overflow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flowtrap_fsm.sv
module flowtrap_fsm
    import flowtrap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_prog,
    input  logic                hit_data,
    input  logic                hit_step,
    input  logic                trap_active,
    input  logic [STATUS_W-1:0] core_status,
    output logic                trap_req,
    output logic [NCAUSE-1:0]   cause,
    output logic [STATUS_W-1:0] snap
);

    trap_state_e state;
    trap_state_e state_nx;
    logic        any_hit;

    always_comb begin
        any_hit = (hit_prog || hit_data || hit_step) && !trap_active;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WATCH: if (any_hit)      state_nx = ST_REQ;
            ST_REQ:   if (trap_active)  state_nx = ST_HELD;
            ST_HELD:  if (!trap_active) state_nx = ST_WATCH;
            default:                    state_nx = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WATCH;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
            snap  <= '0;
        end else if (state == ST_WATCH && any_hit) begin
            cause <= {hit_step, hit_data, hit_prog};
            snap  <= core_status;
        end
    end

    always_comb begin
        trap_req = 1'b0;
        unique case (state)
            ST_WATCH: trap_req = 1'b0;
            ST_REQ:   trap_req = 1'b1;
            ST_HELD:  trap_req = 1'b0;
            default:  trap_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/flowtrap_mon.sv
module flowtrap_mon
    import flowtrap_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_addr,
    input  logic [AW-1:0]              reg_wdata,
    output logic [AW-1:0]              reg_rdata,
    input  logic                       fetch_valid,
    input  logic [AW-1:0]              fetch_addr,
    input  logic                       fetch_dummy,
    input  logic                       data_valid,
    input  logic [AW-1:0]              data_addr,
    input  logic [3:0]                 core_status,
    input  logic                       trap_active,
    output logic                       trap_req,
    input  logic                       trc_rd_en,
    output logic [AW-1:0]              trc_src,
    output logic [AW-1:0]              trc_dst,
    output logic                       trc_empty,
    output logic [$clog2(DEPTH+1)-1:0] trc_count,
    output logic                       trc_overflow
);

    localparam int EW = 2 * AW;

    logic [CTRL_W-1:0]   ctrl_q;
    logic [AW-1:0]       pcmp_q;
    logic [AW-1:0]       dcmp_q;
    logic                real_fetch;
    logic                hit_prog;
    logic                hit_data;
    logic                hit_step;
    logic                clr_ovf;
    logic                push;
    logic [AW-1:0]       push_src;
    logic [AW-1:0]       push_dst;
    logic [EW-1:0]       head;
    logic [NCAUSE-1:0]   cause;
    logic [STATUS_W-1:0] snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pcmp_q <= '0;
            dcmp_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                REG_CTRL: ctrl_q <= reg_wdata[CTRL_W-1:0];
                REG_PCMP: pcmp_q <= reg_wdata;
                REG_DCMP: dcmp_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_ovf    = reg_we && (reg_addr == REG_STAT) && reg_wdata[SB_OVF];
        real_fetch = fetch_valid && !fetch_dummy;
        hit_step   = ctrl_q[CB_STEP] && real_fetch;
    end

    flowtrap_cmp #(.AW(AW)) u_pcmp (
        .enable    (ctrl_q[CB_PROG]),
        .valid     (real_fetch),
        .addr      (fetch_addr),
        .match_val (pcmp_q),
        .hit       (hit_prog)
    );

    flowtrap_cmp #(.AW(AW)) u_dcmp (
        .enable    (ctrl_q[CB_DATA]),
        .valid     (data_valid),
        .addr      (data_addr),
        .match_val (dcmp_q),
        .hit       (hit_data)
    );

    flowtrap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_prog    (hit_prog),
        .hit_data    (hit_data),
        .hit_step    (hit_step),
        .trap_active (trap_active),
        .core_status (core_status),
        .trap_req    (trap_req),
        .cause       (cause),
        .snap        (snap)
    );

    flowtrap_disc #(.AW(AW)) u_disc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_dummy (fetch_dummy),
        .fetch_addr  (fetch_addr),
        .trace_en    (ctrl_q[CB_TRACE]),
        .push        (push),
        .src_addr    (push_src),
        .dst_addr    (push_dst)
    );

    flowtrap_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    ({push_src, push_dst}),
        .pop      (trc_rd_en),
        .clr_ovf  (clr_ovf),
        .rdata    (head),
        .empty    (trc_empty),
        .count    (trc_count),
        .overflow (trc_overflow)
    );

    always_comb begin
        trc_src = head[EW-1:AW];
        trc_dst = head[AW-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            REG_PCMP: reg_rdata = pcmp_q;
            REG_DCMP: reg_rdata = dcmp_q;
            REG_STAT: begin
                reg_rdata[SB_OVF]                        = trc_overflow;
                reg_rdata[SB_REQ]                        = trap_req;
                reg_rdata[SB_CAUSE +: NCAUSE]            = cause;
                reg_rdata[SB_SNAP +: STATUS_W]           = snap;
            end
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flowtrap_mon_chk.sv
module flowtrap_mon_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we,
    input logic [2:0]                 reg_addr,
    input logic [AW-1:0]              reg_wdata,
    input logic                       fetch_valid,
    input logic                       trap_active,
    input logic                       trap_req,
    input logic                       trc_empty,
    input logic [$clog2(DEPTH+1)-1:0] trc_count,
    input logic                       trc_overflow
);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_active) |=> trap_req);

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_active) |=> !trap_req);

    assert_no_rise_in_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> $past(!trap_active));

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_overflow && !(reg_we && reg_addr == 3'd3 && reg_wdata[0])) |=> trc_overflow);

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trc_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_push_needs_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_empty && !fetch_valid) |=> trc_empty);

endmodule

bind flowtrap_mon flowtrap_mon_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .fetch_valid  (fetch_valid),
    .trap_active  (trap_active),
    .trap_req     (trap_req),
    .trc_empty    (trc_empty),
    .trc_count    (trc_count),
    .trc_overflow (trc_overflow)
);

// File: tb/flowtrap_mon_bench.sv
`timescale 1ns/100ps
module flowtrap_mon_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_dummy = 1'b0;
    logic        data_valid = 1'b0;
    logic [15:0] data_addr = '0;
    logic [3:0]  core_status = '0;
    logic        trap_active = 1'b0;
    logic        trap_req;
    logic        trc_rd_en = 1'b0;
    logic [15:0] trc_src;
    logic [15:0] trc_dst;
    logic        trc_empty;
    logic [4:0]  trc_count;
    logic        trc_overflow;

    int          tot = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] expq[$];
    logic [15:0] m_last = '0;
    bit          m_have = 1'b0;
    bit          m_trace = 1'b0;

    always #2.5 clk = ~clk;

    flowtrap_mon u_flowtrap_mon (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_dummy(fetch_dummy), .data_valid(data_valid),
        .data_addr(data_addr), .core_status(core_status), .trap_active(trap_active),
        .trap_req(trap_req), .trc_rd_en(trc_rd_en), .trc_src(trc_src),
        .trc_dst(trc_dst), .trc_empty(trc_empty), .trc_count(trc_count),
        .trc_overflow(trc_overflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tot++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
        if (a == 3'd0) m_trace = d[3];
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: predicts trace pairs into the scoreboard queue
    task automatic fetch(input logic [15:0] a, input bit dummy);
        logic [15:0] nxt;
        fetch_addr = a; fetch_dummy = dummy; fetch_valid = 1'b1;
        if (!dummy) begin
            nxt = m_last + 16'd1;
            if (m_trace && m_have && a != nxt) begin
                if (expq.size() == 16) void'(expq.pop_front());
                expq.push_back({m_last, a});
            end
            m_last = a;
            m_have = 1'b1;
        end
        tick();
        fetch_valid = 1'b0; fetch_dummy = 1'b0;
    endtask

    task automatic release_trap();
        trap_active = 1'b1;
        tick();
        trap_active = 1'b0;
        tick();
    endtask

    task automatic drain();
        while (!trc_empty) begin
            trc_rd_en = 1'b1;
            tick();
        end
        trc_rd_en = 1'b0;
        chk("R10 scoreboard left over", expq.size(), 0);
    endtask

    // monitor: pops expected pairs as the design presents them
    always @(negedge clk) begin
        if (trc_rd_en && !trc_empty) begin
            if (expq.size() == 0) begin
                chk("R10 unexpected entry", {trc_src, trc_dst}, 32'hxxxx_xxxx);
            end else begin
                chk("R10 R8 trace pair", {trc_src, trc_dst}, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tot++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", tot, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 trap_req", trap_req, 0);
        chk("R1 empty", trc_empty, 1);
        chk("R1 count", trc_count, 0);
        chk("R1 overflow", trc_overflow, 0);
        rd(3'd0, r); chk("R1 ctrl", r, 0);

        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0050);
        wr(3'd2, 16'h1234);
        rd(3'd0, r); chk("R12 ctrl", r, 16'h0008);
        rd(3'd1, r); chk("R12 pcmp", r, 16'h0050);
        rd(3'd2, r); chk("R12 dcmp", r, 16'h1234);

        for (int i = 0; i < 4; i++) fetch(16'h0010 + 16'(i), 1'b0);
        chk("R8 sequential no push", trc_count, 0);
        fetch(16'h0040, 1'b0);
        chk("R8 jump pushes", trc_count, 1);
        fetch(16'h0099, 1'b1);
        fetch(16'h0041, 1'b0);
        chk("R9 dummy ignored", trc_count, 1);
        fetch(16'h0060, 1'b0);
        drain();

        wr(3'd0, 16'h0009);
        core_status = 4'hA;
        fetch(16'h004F, 1'b0);
        chk("R2 no early trap", trap_req, 0);
        fetch(16'h0050, 1'b0);
        chk("R2 trap next cycle", trap_req, 1);
        repeat (3) tick();
        chk("R6 held", trap_req, 1);
        rd(3'd3, r);
        chk("R7 prog cause", r[4:2], 3'b001);
        chk("R7 snapshot", r[11:8], 4'hA);
        chk("R7 req mirror", r[1], 1);
        trap_active = 1'b1;
        tick();
        chk("R6 drop after ack", trap_req, 0);
        fetch(16'h0050, 1'b0);
        chk("R6 suppressed while active", trap_req, 0);
        trap_active = 1'b0;
        tick();
        fetch(16'h0050, 1'b1);
        chk("R4 dummy no match", trap_req, 0);
        wr(3'd0, 16'h0008);
        fetch(16'h0050, 1'b0);
        chk("R4 disabled no match", trap_req, 0);

        wr(3'd0, 16'h000A);
        core_status = 4'h3;
        data_addr = 16'h1235; data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
        chk("R3 mismatch", trap_req, 0);
        data_addr = 16'h1234; data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
        chk("R3 data trap", trap_req, 1);
        rd(3'd3, r);
        chk("R7 data cause", r[4:2], 3'b010);
        chk("R7 snapshot data", r[11:8], 4'h3);
        release_trap();

        wr(3'd0, 16'h000C);
        fetch(16'h0070, 1'b0);
        chk("R5 step trap", trap_req, 1);
        rd(3'd3, r);
        chk("R7 step cause", r[4:2], 3'b100);
        release_trap();
        fetch(16'h0071, 1'b0);
        chk("R5 step again", trap_req, 1);
        release_trap();
        fetch(16'h0072, 1'b1);
        chk("R4 dummy no step", trap_req, 0);
        wr(3'd0, 16'h0008);
        drain();

        for (int k = 1; k <= 17; k++) fetch(16'(k * 256), 1'b0);
        chk("R11 count full", trc_count, 16);
        chk("R11 overflow set", trc_overflow, 1);
        rd(3'd3, r); chk("R11 stat ovf", r[0], 1);
        drain();
        chk("R11 sticky", trc_overflow, 1);
        wr(3'd3, 16'h0001);
        chk("R11 cleared", trc_overflow, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

endmodule